// File: doc/BRIEF.md
# Carry-Select Wide Adder

This block adds two wide unsigned operands and a carry-in, giving a full-width sum and a carry-out. It has no clock and no state. Each operand is cut into a lower and an upper half of equal width. The lower half is added with the real carry-in. The upper half is added twice at the same time, once as if no carry came up from below and once as if one did. When the lower carry is known, it only has to steer a multiplexer. It does not have to ripple through the upper half. Both the upper sum and the final carry-out come through that multiplexer.

The half width is a parameter, with a default of 32 for a 64-bit adder. A narrow instance keeps the same structure, so every input can be tried on it.

Top module: `csel_add`

## Requirements
- R1: `sum_out` equals (`opnd_a` + `opnd_b` + `carry_in`) modulo 2^(2*HALF_W), with all values unsigned.
- R2: `carry_out` equals bit 2*HALF_W of the true sum `opnd_a + opnd_b + carry_in`.
- R3: The lower HALF_W bits of `sum_out` depend only on the lower halves of the operands and on `carry_in`. Changing the upper operand bits leaves them unchanged.
- R4: When the lower halves plus `carry_in` reach or pass 2^HALF_W, the upper half of `sum_out` is the sum of the upper operand halves plus one, wrapped to HALF_W bits. This includes the exact boundary, where the lower halves sum to all ones and `carry_in` is 1.
- R5: When the lower halves plus `carry_in` stay below 2^HALF_W, the upper half of `sum_out` is the plain sum of the upper operand halves, wrapped to HALF_W bits. This includes the case where the lower sum is exactly all ones.
- R6: All-ones operands with `carry_in` = 1 give an all-ones `sum_out` and `carry_out` = 1. All-ones operands with `carry_in` = 0 give all ones except bit 0, with `carry_out` = 1.
- R7: The block holds no state. The outputs follow the present inputs without any clock edge, and the same inputs always give the same outputs, whatever was applied before.
- R8: Every result above holds at any legal HALF_W. With HALF_W = 4, every possible input (8-bit operands and both carry values) gives the exact 9-bit sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 2*HALF_W | First operand, unsigned |
| opnd_b | input | 2*HALF_W | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 2*HALF_W | Sum, modulo 2^(2*HALF_W) |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The hard case to reach is the exact carry boundary at the halfway point. The lower halves must sum to all ones. Then the upper result depends only on `carry_in`, which makes the two speculative upper sums differ at their edge. Random operands almost never land there. Directed vectors therefore pin the lower halves to all-ones patterns, and to patterns one short of all ones, with both carry-in values. Upper halves of all ones are added so that a wrong selection also shows up on `carry_out`. A second instance with 4-bit halves is swept over every input, which covers the boundary for every upper value.

// File: rtl/csel_pkg.sv
package csel_pkg;
    // Default width of one half of the adder
    localparam int DEF_HALF_W = 32;
    // Number of speculative copies of the upper half (carry assumed 0 and 1)
    localparam int SPEC_COPIES = 2;
endpackage

// File: rtl/csel_ripple.sv
// Ripple adder over one half: WIDTH bits plus a carry in.
module csel_ripple #(
    parameter int WIDTH = csel_pkg::DEF_HALF_W
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] s_out,
    output logic             c_out
);
    logic [WIDTH-1:0] s_d;
    logic             c_d;

    always_comb begin
        logic chain;
        chain = c_in;
        for (int i = 0; i < WIDTH; i++) begin
            s_d[i] = a_in[i] ^ b_in[i] ^ chain;
            chain  = (a_in[i] & b_in[i]) | (chain & (a_in[i] ^ b_in[i]));
        end
        c_d = chain;
    end

    assign s_out = s_d;
    assign c_out = c_d;
endmodule

// File: rtl/csel_spec_upper.sv
// Upper half evaluated once per possible incoming carry value.
module csel_spec_upper #(
    parameter int WIDTH = csel_pkg::DEF_HALF_W
) (
    input  logic [WIDTH-1:0] a_hi,
    input  logic [WIDTH-1:0] b_hi,
    output logic [WIDTH-1:0] spec_s [csel_pkg::SPEC_COPIES],
    output logic             spec_c [csel_pkg::SPEC_COPIES]
);
    for (genvar k = 0; k < csel_pkg::SPEC_COPIES; k++) begin : g_copy
        csel_ripple #(.WIDTH(WIDTH)) u_add (
            .a_in  (a_hi),
            .b_in  (b_hi),
            .c_in  (k[0]),
            .s_out (spec_s[k]),
            .c_out (spec_c[k])
        );
    end
endmodule

// File: rtl/csel_pick.sv
// Selection stage: the lower carry picks one speculative result.
module csel_pick #(
    parameter int WIDTH = csel_pkg::DEF_HALF_W
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] s_if0,
    input  logic             c_if0,
    input  logic [WIDTH-1:0] s_if1,
    input  logic             c_if1,
    output logic [WIDTH-1:0] s_out,
    output logic             c_out
);
    always_comb begin
        if (sel) begin
            s_out = s_if1;
            c_out = c_if1;
        end else begin
            s_out = s_if0;
            c_out = c_if0;
        end
    end
endmodule

// File: rtl/csel_add.sv
module csel_add #(
    parameter int HALF_W = csel_pkg::DEF_HALF_W,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic [FULL_W-1:0] opnd_a,
    input  logic [FULL_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic [FULL_W-1:0] sum_out,
    output logic              carry_out
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic              cout;
    } result_t;

    logic [HALF_W-1:0] lo_sum;
    logic              lo_carry;
    logic [HALF_W-1:0] spec_sum   [csel_pkg::SPEC_COPIES];
    logic              spec_carry [csel_pkg::SPEC_COPIES];
    logic [HALF_W-1:0] hi_pick;
    logic              c_pick;
    result_t           res_d;

    // Lower half takes the external carry
    csel_ripple #(.WIDTH(HALF_W)) u_lo (
        .a_in  (opnd_a[HALF_W-1:0]),
        .b_in  (opnd_b[HALF_W-1:0]),
        .c_in  (carry_in),
        .s_out (lo_sum),
        .c_out (lo_carry)
    );

    // Upper half, both carry assumptions in parallel
    csel_spec_upper #(.WIDTH(HALF_W)) u_hi (
        .a_hi   (opnd_a[FULL_W-1:HALF_W]),
        .b_hi   (opnd_b[FULL_W-1:HALF_W]),
        .spec_s (spec_sum),
        .spec_c (spec_carry)
    );

    csel_pick #(.WIDTH(HALF_W)) u_pick (
        .sel   (lo_carry),
        .s_if0 (spec_sum[0]),
        .c_if0 (spec_carry[0]),
        .s_if1 (spec_sum[1]),
        .c_if1 (spec_carry[1]),
        .s_out (hi_pick),
        .c_out (c_pick)
    );

    always_comb begin
        res_d.lo   = lo_sum;
        res_d.hi   = hi_pick;
        res_d.cout = c_pick;
    end

    assign sum_out   = {res_d.hi, res_d.lo};
    assign carry_out = res_d.cout;
endmodule

// File: rtl/csel_add_chk.sv
module csel_add_chk #(
    parameter int HALF_W = csel_pkg::DEF_HALF_W,
    localparam int FULL_W = 2 * HALF_W
) (
    input logic [FULL_W-1:0] opnd_a,
    input logic [FULL_W-1:0] opnd_b,
    input logic              carry_in,
    input logic [FULL_W-1:0] sum_out,
    input logic              carry_out,
    input logic [HALF_W-1:0] spec_hi0,
    input logic [HALF_W-1:0] spec_hi1
);
    logic [FULL_W:0] ref_full;
    logic [HALF_W:0] ref_lo;
    logic [HALF_W:0] ref_hi;

    always_comb begin
        ref_full = {1'b0, opnd_a} + {1'b0, opnd_b} + {{FULL_W{1'b0}}, carry_in};
        ref_lo   = {1'b0, opnd_a[HALF_W-1:0]} + {1'b0, opnd_b[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, carry_in};
        ref_hi   = {1'b0, opnd_a[FULL_W-1:HALF_W]} + {1'b0, opnd_b[FULL_W-1:HALF_W]};
        if (!$isunknown({opnd_a, opnd_b, carry_in, sum_out, carry_out, spec_hi0, spec_hi1})) begin
            AST_SUM_MATCH: assert (sum_out == ref_full[FULL_W-1:0]) else $error("sum mismatch"); // R1
            AST_CARRY_MATCH: assert (carry_out == ref_full[FULL_W]) else $error("carry mismatch"); // R2
            AST_LOW_HALF: assert (sum_out[HALF_W-1:0] == ref_lo[HALF_W-1:0]) else $error("low half"); // R3
            AST_HI_WITH_CARRY: assert (!ref_lo[HALF_W] || sum_out[FULL_W-1:HALF_W] == ref_hi[HALF_W-1:0] + 1'b1) else $error("upper with carry"); // R4
            AST_HI_NO_CARRY: assert (ref_lo[HALF_W] || sum_out[FULL_W-1:HALF_W] == ref_hi[HALF_W-1:0]) else $error("upper without carry"); // R5
            AST_SPEC_STEP: assert (spec_hi1 == spec_hi0 + 1'b1) else $error("speculative copies disagree"); // R4
        end
    end
endmodule

bind csel_add csel_add_chk #(.HALF_W(HALF_W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .spec_hi0  (spec_sum[0]),
    .spec_hi1  (spec_sum[1])
);

// File: tb/tb_csel_add.sv
module tb_csel_add;
    localparam int W  = 64;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0]  a, b, s;
    logic          ci, co;
    logic [SW-1:0] sa, sb, ss;
    logic          sci, sco;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    csel_add dut (.opnd_a(a), .opnd_b(b), .carry_in(ci), .sum_out(s), .carry_out(co));
    csel_add #(.HALF_W(4)) dut_small (.opnd_a(sa), .opnd_b(sb), .carry_in(sci),
                                      .sum_out(ss), .carry_out(sco));

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         c;
        logic [W-1:0] s;
        logic         co;
        logic [7:0]   tag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 8'd1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 64'h0, 1'b1, 8'd2},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8'd6},
        '{64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, 64'h0000_0001_0000_0000, 1'b0, 8'd4},
        '{64'h0000_0000_FFFF_FFFE, 64'h1, 1'b0, 64'h0000_0000_FFFF_FFFF, 1'b0, 8'd5},
        '{64'h0000_0000_FFFF_FFFF, 64'h0, 1'b1, 64'h0000_0001_0000_0000, 1'b0, 8'd4},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'd5},
        '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 64'h0, 1'b1, 8'd2},
        '{64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 1'b0, 64'h0, 1'b1, 8'd5},
        '{64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 1'b0, 64'h2345_6789_ABCD_F001, 1'b0, 8'd1},
        '{64'hFFFF_FFFF_8000_0000, 64'h0000_0000_8000_0000, 1'b1, 64'h0000_0000_0000_0001, 1'b1, 8'd4}
    };

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ra, rb, hold_s;
        logic         hold_c;
        a = '0; b = '0; ci = 1'b0;
        sa = '0; sb = '0; sci = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R7: no state, zero inputs give zero result straight after reset
        check("R7 reset", {co, s}, {1'b0, {W{1'b0}}});
        rst_n = 1'b1;

        // Table walk: R1 R2 R4 R5 R6 boundaries
        for (int i = 0; i < NV; i++) begin
            a = VECS[i].a; b = VECS[i].b; ci = VECS[i].c;
            #1;
            check($sformatf("R1/R2 vec%0d (R%0d)", i, VECS[i].tag), {co, s}, {VECS[i].co, VECS[i].s});
        end

        // R6: all ones with carry-in 0
        a = '1; b = '1; ci = 1'b0; #1;
        check("R6 all-ones cin0", {co, s}, {1'b1, {{(W-1){1'b1}}, 1'b0}});

        // Random vectors against the 65-bit model
        for (int i = 0; i < 400; i++) begin
            a = {$urandom, $urandom}; b = {$urandom, $urandom}; ci = 1'(i);
            #1;
            check("R1 random", {co, s}, model(a, b, ci));
        end

        // R4/R5: lower halves forced to the boundary with random upper halves
        for (int i = 0; i < 64; i++) begin
            ra = {$urandom, 32'h0};
            rb = {$urandom, 32'h0};
            a = ra | 64'h0000_0000_FFFF_FFFF;
            b = rb;
            ci = 1'b1; #1;
            check("R4 exact carry", {co, s}, model(a, b, ci));
            ci = 1'b0; #1;
            check("R5 exact no-carry", {co, s}, model(a, b, ci));
        end

        // R3: upper operand bits do not touch the low half
        a = 64'h0000_0000_89AB_CDEF; b = 64'h0000_0000_7654_3210; ci = 1'b1; #1;
        hold_s = s;
        for (int i = 0; i < 8; i++) begin
            a[63:32] = $urandom; b[63:32] = $urandom; #1;
            check("R3 low half isolation", {1'b0, 32'h0, s[31:0]}, {1'b0, 32'h0, hold_s[31:0]});
        end

        // R7: repeat a vector after different history
        a = 64'hDEAD_BEEF_FFFF_FFFF; b = 64'h1; ci = 1'b0; #1;
        hold_s = s; hold_c = co;
        a = '1; b = '1; ci = 1'b1; #1;
        a = 64'hDEAD_BEEF_FFFF_FFFF; b = 64'h1; ci = 1'b0; #1;
        check("R7 history independence", {co, s}, {hold_c, hold_s});
        check("R7 value", {co, s}, model(a, b, ci));

        // R8: exhaustive at 4-bit halves
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int c = 0; c < 2; c++) begin
                    sa = 8'(x); sb = 8'(y); sci = 1'(c);
                    #1;
                    check("R8 exhaustive narrow", {{(W-SW){1'b0}}, sco, ss}, 65'(x + y + c));
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule